// File: doc/BRIEF.md
# Pixel-to-Lane Serial Packer for Flat-Panel Links

This block accepts one parallel pixel per pixel period: 8-bit red, green and blue, plus horizontal sync, vertical sync and data enable. It rearranges the 24 colour bits and three control bits into one seven-bit word for each of up to four data lanes. The arrangement follows one of three colour layouts, chosen at run time. It then sends every word out one bit per fast-clock cycle. A fifth lane carries a fixed framing pattern that a receiver uses to find word boundaries.

All of the logic runs on a single fast clock. The pixel rate is given by a strobe `pix_stb` that is high for one fast cycle in every seven. The pixel inputs are latched in the strobe cycle. A mirror option reverses the slot order on all data lanes. The layout and mirror settings are taken only during vertical blanking, so a frame is never split between two settings.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: After reset, and until the first strobe, every data lane and the clock lane are held low.
- R2: The pixel inputs are captured at the rising edge that sees `pix_stb` high. Slot k of that word is on the lanes during fast cycle k+1 after that edge, for k = 0 to 6. With a strobe every seven cycles, slot 0 of the next word follows slot 6 immediately, with no idle cycle.
- R3: The clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 for every word, whatever the mirror setting.
- R4: Narrow layout (`map_sel` = 0, and also 3): only bits 7:2 of each channel are sent, numbered 5..0. Lane 0 carries G0,R5,R4,R3,R2,R1,R0 in slots 0..6. Lane 1 carries B1,B0,G5,G4,G3,G2,G1. Lane 2 carries CTL2,CTL1,CTL0,B5,B4,B3,B2. Lane 3 stays low.
- R5: First wide layout (`map_sel` = 1): lanes 0 to 2 are the same as in R4, still taken from bits 7:2. Lane 3 carries CTL3,B1,B0,G1,G0,R1,R0 in slots 0..6, using channel bits 1:0.
- R6: Second wide layout (`map_sel` = 2): lanes 0 to 2 follow the R4 pattern, but the six numbered bits are channel bits 5:0. Lane 3 carries CTL3,B7,B6,G7,G6,R7,R6 in slots 0..6.
- R7: The control slots carry CTL0 = `hsync`, CTL1 = `vsync` and CTL2 = `de`. CTL3 is always 0.
- R8: When the mirror setting is 1, each data lane sends slot 6 first and slot 0 last.
- R9: `map_sel` and `mirror` are taken only at a strobe where `de` is 0 and `vsync` is 1 (vertical sync is active-high). The new setting already applies to the word latched at that strobe. At every other time these inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial clock, seven cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_stb | input | 1 | Pixel strobe, high for one cycle in seven |
| red | input | 8 | Red channel |
| green | input | 8 | Green channel |
| blue | input | 8 | Blue channel |
| hsync | input | 1 | Horizontal sync (CTL0) |
| vsync | input | 1 | Vertical sync, active-high (CTL1) |
| de | input | 1 | Data enable (CTL2) |
| map_sel | input | 2 | Layout select: 0/3 narrow, 1 first wide, 2 second wide |
| mirror | input | 1 | Reverse the slot order on the data lanes |
| lane_data | output | 4 | Serial data lanes 3..0 |
| lane_clk | output | 1 | Serial framing-clock lane |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that `pix_stb` is never high on two consecutive cycles, so the cycle after a strobe always shows slot 0 of the word just latched. The bench produces the strobe from a fixed seven-cycle loop, keeps the strobe low during reset, and changes inputs only at falling edges. It changes `map_sel` and `mirror` while `de` is high and while `vsync` is low during blanking. This shows that these inputs are ignored there and are taken only at qualifying blanking strobes.

// File: rtl/lvds_ser_pkg.sv
// Package: constants and layout-select type shared by the pixel serializer.
// Assumes seven slots per pixel period and at most four data lanes.
package lvds_ser_pkg;
    localparam int SLOT_N = 7;
    localparam int LANE_N = 4;
    localparam int CH_W   = 8;
    localparam int SUB_W  = 6;

    typedef enum logic [1:0] {
        MAP_NARROW = 2'd0,
        MAP_WIDE_A = 2'd1,
        MAP_WIDE_B = 2'd2,
        MAP_RSVD   = 2'd3
    } map_e;

    // Framing pattern, bit k = slot k: 1,1,0,0,0,1,1
    localparam logic [SLOT_N-1:0] CLK_WORD = 7'b1100011;
endpackage

// File: rtl/lvds_cfg_hold.sv
// Module: holds the layout and mirror settings. They are updated only at a
// strobe during vertical blanking (de low, vsync high).
// Assumes vsync is active-high. The new setting is passed through in the
// same cycle so that the word latched at that strobe already uses it.
module lvds_cfg_hold
    import lvds_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_stb,
    input  logic       de,
    input  logic       vsync,
    input  logic [1:0] map_sel,
    input  logic       mirror,
    output map_e       mode_q,
    output logic       mir_q,
    output map_e       mode_use,
    output logic       mir_use
);
    logic take;

    // Decide whether this cycle is a qualifying blanking strobe
    always_comb begin
        take     = pix_stb && !de && vsync;
        mode_use = take ? map_e'(map_sel) : mode_q;
        mir_use  = take ? mirror : mir_q;
    end

    // Store the setting taken at a qualifying strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MAP_NARROW;
            mir_q  <= 1'b0;
        end else if (take) begin
            mode_q <= map_e'(map_sel);
            mir_q  <= mirror;
        end
    end
endmodule

// File: rtl/lvds_lane_mapper.sv
// Module: combinational packing of one pixel into per-lane seven-bit words,
// where bit k of each word is slot k.
// Assumes the layout code has already been resolved; code 3 is treated as narrow.
module lvds_lane_mapper
    import lvds_ser_pkg::*;
(
    input  map_e                           mode,
    input  logic [CH_W-1:0]                red,
    input  logic [CH_W-1:0]                green,
    input  logic [CH_W-1:0]                blue,
    input  logic                           hsync,
    input  logic                           vsync,
    input  logic                           de,
    output logic [LANE_N-1:0][SLOT_N-1:0]  words
);
    logic [SUB_W-1:0] rc, gc, bc;

    // Pick the six bits per channel carried on lanes 0..2, then arrange all lanes
    always_comb begin
        if (mode == MAP_WIDE_B) begin
            rc = red[SUB_W-1:0];
            gc = green[SUB_W-1:0];
            bc = blue[SUB_W-1:0];
        end else begin
            rc = red[CH_W-1:CH_W-SUB_W];
            gc = green[CH_W-1:CH_W-SUB_W];
            bc = blue[CH_W-1:CH_W-SUB_W];
        end
        words[0] = {rc[0], rc[1], rc[2], rc[3], rc[4], rc[5], gc[0]};
        words[1] = {gc[1], gc[2], gc[3], gc[4], gc[5], bc[0], bc[1]};
        words[2] = {bc[2], bc[3], bc[4], bc[5], hsync, vsync, de};
        case (mode)
            MAP_WIDE_A: words[3] = {red[0], red[1], green[0], green[1],
                                    blue[0], blue[1], 1'b0};
            MAP_WIDE_B: words[3] = {red[6], red[7], green[6], green[7],
                                    blue[6], blue[7], 1'b0};
            default:    words[3] = '0;
        endcase
    end
endmodule

// File: rtl/lvds_slot_shifter.sv
// Module: one serial lane. The word is loaded on the strobe, optionally
// slot-reversed, and then shifted out with slot 0 first.
// Assumes the strobe period equals WORD_W so that the next load follows the last slot.
module lvds_slot_shifter #(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rev,
    input  logic [WORD_W-1:0] word,
    output logic              ser
);
    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] ordered;

    // Slot reversal network
    for (genvar i = 0; i < WORD_W; i++) begin : g_rev
        assign ordered[i] = rev ? word[WORD_W-1-i] : word[i];
    end

    // Load on strobe, otherwise move the next slot to the output
    always_ff @(posedge clk) begin
        if (!rst_n)    sreg <= '0;
        else if (load) sreg <= ordered;
        else           sreg <= {1'b0, sreg[WORD_W-1:1]};
    end

    assign ser = sreg[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
// Module: top level of the pixel serializer. It combines the settings hold,
// the lane mapper, one shifter per data lane and a framing-clock shifter.
// Assumes pix_stb is high for one cycle in every SLOT_N cycles.
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic [CH_W-1:0]   red,
    input  logic [CH_W-1:0]   green,
    input  logic [CH_W-1:0]   blue,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              de,
    input  logic [1:0]        map_sel,
    input  logic              mirror,
    output logic [LANE_N-1:0] lane_data,
    output logic              lane_clk
);
    map_e cfg_mode_q, cfg_mode_use;
    logic cfg_mir_q, cfg_mir_use;
    logic [LANE_N-1:0][SLOT_N-1:0] words;

    lvds_cfg_hold cfg_i (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .de(de), .vsync(vsync),
        .map_sel(map_sel), .mirror(mirror),
        .mode_q(cfg_mode_q), .mir_q(cfg_mir_q),
        .mode_use(cfg_mode_use), .mir_use(cfg_mir_use)
    );

    lvds_lane_mapper map_i (
        .mode(cfg_mode_use), .red(red), .green(green), .blue(blue),
        .hsync(hsync), .vsync(vsync), .de(de), .words(words)
    );

    // One shifter per data lane
    for (genvar l = 0; l < LANE_N; l++) begin : g_lane
        lvds_slot_shifter #(.WORD_W(SLOT_N)) shf_i (
            .clk(clk), .rst_n(rst_n), .load(pix_stb), .rev(cfg_mir_use),
            .word(words[l]), .ser(lane_data[l])
        );
    end

    // Framing-clock lane, never reversed
    lvds_slot_shifter #(.WORD_W(SLOT_N)) clk_shf_i (
        .clk(clk), .rst_n(rst_n), .load(pix_stb), .rev(1'b0),
        .word(CLK_WORD), .ser(lane_clk)
    );
endmodule

// File: rtl/lvds_pixel_serializer_chk.sv
// Module: assertion checker bound to the serializer top.
// Assumes pix_stb is never high on two consecutive cycles.
module lvds_pixel_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_stb,
    input logic       de,
    input logic       vsync,
    input logic [3:0] lane_data,
    input logic       lane_clk,
    input logic [1:0] mode_q,
    input logic       mir_q,
    input logic       mir_use
);
    logic seen_stb;

    // Record whether any strobe has been seen since reset
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_stb <= 1'b0;
        else if (pix_stb) seen_stb <= 1'b1;
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_stb |-> (lane_data == 4'b0) && !lane_clk);

    p_clk_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_stb) && $past(rst_n) |-> lane_clk);

    p_ctl3_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_stb) && $past(rst_n) && !$past(mir_use) |-> !lane_data[3]);

    p_de_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_stb) && $past(rst_n) && !$past(mir_use) |-> lane_data[2] == $past(de));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_stb && !de && vsync) |=> $stable(mode_q) && $stable(mir_q));
endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .de(de), .vsync(vsync),
    .lane_data(lane_data), .lane_clk(lane_clk),
    .mode_q(cfg_mode_q), .mir_q(cfg_mir_q), .mir_use(cfg_mir_use)
);

// File: tb/lvds_pixel_serializer_tb_top.sv
// Bench: sweeps every layout code with both mirror settings, using walking-one,
// control-combination and pseudo-random pixels. Expected slots are computed from
// the requirement tables.
module lvds_pixel_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, pix_stb, hsync, vsync, de, mirror;
    logic [7:0] red, green, blue;
    logic [1:0] map_sel;
    logic [3:0] lane_data;
    logic       lane_clk;

    int checks = 0;
    int errors = 0;
    logic [1:0]  m_mode;
    logic        m_mir;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    lvds_pixel_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .red(red), .green(green),
        .blue(blue), .hsync(hsync), .vsync(vsync), .de(de), .map_sel(map_sel),
        .mirror(mirror), .lane_data(lane_data), .lane_clk(lane_clk)
    );

    // Expected bit of one lane in one (unmirrored) slot, from R4..R7
    function automatic logic exp_bit(input logic [1:0] md, input int lane, input int s,
                                     input logic [7:0] r, g, b, input logic h, v, d);
        int lo;
        lo = (md == 2'd2) ? 0 : 2;
        case (lane)
            0: return (s == 0) ? g[lo] : r[lo + 6 - s];
            1: return (s == 0) ? b[lo + 1] : (s == 1) ? b[lo] : g[lo + 7 - s];
            2: return (s == 0) ? d : (s == 1) ? v : (s == 2) ? h : b[lo + 8 - s];
            default: begin
                if (md == 2'd1) begin
                    case (s)
                        1: return b[1]; 2: return b[0]; 3: return g[1];
                        4: return g[0]; 5: return r[1]; 6: return r[0];
                        default: return 1'b0;
                    endcase
                end else if (md == 2'd2) begin
                    case (s)
                        1: return b[7]; 2: return b[6]; 3: return g[7];
                        4: return g[6]; 5: return r[7]; 6: return r[6];
                        default: return 1'b0;
                    endcase
                end
                return 1'b0;
            end
        endcase
    endfunction

    // Drive one pixel with a strobe, then check all seven slots (R2, R3, R7, R8, R9)
    task automatic send(input logic [7:0] r, g, b, input logic h, v, d,
                        input logic [1:0] sel, input logic mir);
        logic [4:0] exp;
        string tag;
        red = r; green = g; blue = b; hsync = h; vsync = v; de = d;
        map_sel = sel; mirror = mir; pix_stb = 1'b1;
        if (!d && v) begin m_mode = sel; m_mir = mir; end
        tag = (m_mode == 2'd1) ? "R5" : (m_mode == 2'd2) ? "R6" : "R4";
        @(negedge clk);
        pix_stb = 1'b0;
        for (int k = 0; k < 7; k++) begin
            int src;
            src = m_mir ? 6 - k : k;
            exp[4] = (k < 2) || (k > 4);
            for (int l = 0; l < 4; l++) exp[l] = exp_bit(m_mode, l, src, r, g, b, h, v, d);
            checks++;
            if ({lane_clk, lane_data} !== exp) begin
                errors++;
                $display("FAIL %s (R2 R3 R7 R8 R9) mir=%0d slot %0d: got %b expected %b",
                         tag, m_mir, k, {lane_clk, lane_data}, exp);
            end
            if (k < 6) @(negedge clk);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        return x * 32'd1103515245 + 32'd12345;
    endfunction

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_stb = 1'b0; red = '0; green = '0; blue = '0;
        hsync = 1'b0; vsync = 1'b0; de = 1'b0; map_sel = '0; mirror = 1'b0;
        m_mode = 2'd0; m_mir = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet until the first strobe
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            checks++;
            if ({lane_clk, lane_data} !== 5'b0) begin
                errors++;
                $display("FAIL R1 idle: got %b expected %b", {lane_clk, lane_data}, 5'b0);
            end
        end
        for (int sel = 0; sel < 4; sel++) begin
            for (int mir = 0; mir < 2; mir++) begin
                // Qualifying blanking strobe sets the layout (R9)
                seed = next_rand(seed);
                send(seed[7:0], seed[15:8], seed[23:16], 1'b1, 1'b1, 1'b0,
                     2'(sel), 1'(mir));
                // Walking ones with conflicting settings while de is high (R9 ignored)
                for (int w = 0; w < 24; w++) begin
                    logic [23:0] pat;
                    pat = 24'd1 << w;
                    send(pat[7:0], pat[15:8], pat[23:16], 1'b0, 1'b0, 1'b1,
                         2'(~sel), 1'(~mir));
                end
                // Control combinations; blanking with vsync low is also ignored
                for (int c = 0; c < 8; c++) begin
                    logic [2:0] cc;
                    cc = 3'(c);
                    if (!cc[2] && cc[1])
                        send(8'hA5, 8'h5A, 8'hC3, cc[0], cc[1], cc[2], 2'(sel), 1'(mir));
                    else
                        send(8'hA5, 8'h5A, 8'hC3, cc[0], cc[1], cc[2], 2'(sel + 1), 1'(~mir));
                end
                // Pseudo-random active pixels
                for (int p = 0; p < 8; p++) begin
                    seed = next_rand(seed);
                    send(seed[31:24], seed[23:16], seed[15:8], seed[3], seed[4], 1'b1,
                         seed[6:5], seed[7]);
                end
            end
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule